// File: doc/BRIEF.md
# Command-Tagged SPI Master Engine

This block is an SPI bus master driven from a four-entry transmit queue of 32-bit push words. The upper half of every push word is a per-frame command, and the lower half is the data to shift out. The command picks the chip-select line or lines for the frame. It also says whether chip select stays asserted into the next frame, whether the frame ends a queue, and whether the transfer counter restarts with this frame. The attribute-set field (command bits 13:12) is accepted and ignored, because the block holds a single attribute set. That set gives the frame length (4 to 16 bits), clock polarity, clock phase, bit order and the SCK half-period. Every received frame goes into a four-entry receive queue. Software reads it back through a small register port.

The engine is a five-state machine. IDLE waits. It starts a frame (IDLE→SETUP, popping one push word) when the master enable is set, the transmit queue holds a word and the receive queue has room. SETUP holds chip select asserted with SCK at its idle level for one half period, then moves to HALF1. HALF1 drives the first half of a bit and samples MISO at its end, then moves to HALF2. HALF2 drives the second half. From HALF2 the machine returns to HALF1 for the next bit, or goes to HOLD after the last bit. HOLD leaves SCK idle for one half period. It then writes the received frame, counts it, raises the flags and returns to IDLE. On that return chip select is released unless the continue bit was set.

Registers, selected by `reg_addr`:
- 0, control: bit 0 enables the master. Bits 13:8 give the inactive level of each chip-select line (reset 6'h3F). Writing 1 to bit 4 empties the transmit queue and writing 1 to bit 5 empties the receive queue; neither bit is stored.
- 1, attributes: bits 3:0 hold the frame length minus one (reset 7). Bit 4 is CPOL, bit 5 is CPHA and bit 6 selects LSB first. Bits 15:8 hold the half-period minus one, in clock cycles.
- 2, transfer count: bits 31:16, read only.
- 3, status: bit 31 frame done, bit 28 end of queue, bit 1 push overflow, bit 0 pop underflow. Each bit is cleared by writing 1.
- 4, interrupt enables: bit 31 and bit 28.
- 5, push: write only.
- 6, pop: read. The frame is in bits 15:0.

Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds there until the next read.

Top module: `spim_engine`

## Requirements
- R1: After reset, control reads 32'h0000_3F00, attributes read 32'h0000_0007, status and count read 0, `sel_o` is 6'h3F, and `sck` and `irq` are 0.
- R2: A frame shifts out length bits of push-word bits 15:0 on MOSI. The length is the attribute field plus one, and field values below 3 give 4 bits.
- R3: While no frame is in progress, SCK rests at CPOL. MOSI is sampled on the leading SCK edge when CPHA=0 and on the trailing edge when CPHA=1. Each SCK half period lasts the divider field plus one clock cycles.
- R4: With bit 6 of the attributes at 0 the most significant frame bit goes first; with it at 1 bit 0 goes first.
- R5: A pop of a non-empty receive queue returns the received frame in bits 15:0 in the order it was sent. All bits above the frame length read 0.
- R6: During a frame, each line chosen by command bits 5:0 is driven to the inverse of its inactive level. Every other line, and every line between frames, stays at its inactive level.
- R7: If command bit 15 is 1, chip select stays asserted from the end of the frame into the next frame. If it is 0, chip select returns to the inactive level after the frame.
- R8: Each completed frame adds one to count bits 31:16. A frame whose command bit 10 is 1 first zeroes the count, so it leaves the count at 1.
- R9: Every completed frame sets status bit 31. A frame with command bit 11 also sets status bit 28. Writing 1 to a status bit clears it.
- R10: `irq` is 1 exactly when a status bit among 31 and 28 is set and its enable bit (the same position in register 4) is set.
- R11: A push while the transmit queue holds 4 words is dropped and sets status bit 1.
- R12: A pop of an empty receive queue returns 0 and sets status bit 0.
- R13: Writing 1 to control bit 4 discards all queued push words, and writing 1 to control bit 5 discards all received frames.
- R14: No frame starts while the master enable is 0 or the receive queue holds 4 frames. A frame waiting for room starts after a pop, so no received frame is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops on register 6 |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_o | output | 6 | Chip-select lines |

## Verification
The bench loops MISO back through an inverter. It then sweeps every frame-length field from 1 to 15 through all four clock modes and both bit orders. This separates length decoding, the sampling edge and the bit reversal, and each pattern is checked both on the wire and through the receive queue. Frames with and without the continue bit tell chip-select holding from release, which the bench sees as a count of deassertions. Counter-clear frames tell restart from accumulation. Pushing into a full transmit queue and starving the receive queue tell dropping from stalling. A changed idle level and a slower divider show that level inversion and half-period timing are both programmable.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int DATA_W = 16;
    localparam int CS_W   = 6;
    localparam int FSZ_W  = 4;

    // command half-word bit positions
    localparam int CMD_CONT = 15;
    localparam int CMD_EOQ  = 11;
    localparam int CMD_CLR  = 10;

    // register indices
    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_ATTR  = 3'd1;
    localparam logic [2:0] RA_COUNT = 3'd2;
    localparam logic [2:0] RA_STAT  = 3'd3;
    localparam logic [2:0] RA_IRQEN = 3'd4;
    localparam logic [2:0] RA_PUSH  = 3'd5;
    localparam logic [2:0] RA_POP   = 3'd6;

    // status bits
    localparam int SB_DONE = 31;
    localparam int SB_EOQ  = 28;
    localparam int SB_OVF  = 1;
    localparam int SB_UDF  = 0;

    // control bits
    localparam int CB_EN    = 0;
    localparam int CB_FLTX  = 4;
    localparam int CB_FLRX  = 5;
    localparam int CB_LVL   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HALF1,
        ST_HALF2,
        ST_HOLD
    } eng_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign dout  = mem[rp[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else if (flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full)  wp <= wp + 1'b1;
            if (pop && !empty)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full && !flush) mem[wp[AW-1:0]] <= din;
    end
endmodule

// File: rtl/spim_core.sv
module spim_core
    import spim_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic [31:0]       tx_word,
    input  logic [FSZ_W-1:0]  fsz,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              miso,
    output logic              tx_pop,
    output logic              frame_end,
    output logic              frame_eoq,
    output logic              cnt_clear,
    output logic [DATA_W-1:0] rx_data,
    output logic [CS_W-1:0]   cs_act,
    output logic              busy,
    output logic              sck,
    output logic              mosi
);
    eng_state_e          state, state_n;
    logic [DIV_W-1:0]    tick;
    logic [FSZ_W-1:0]    idx;
    logic [15:0]         cmd_q;
    logic [DATA_W-1:0]   data_q;
    logic [DATA_W-1:0]   rx_sh;
    logic [CS_W-1:0]     cs_hold;
    logic                half_end;
    logic [FSZ_W-1:0]    bit_pos;

    assign half_end = (tick == half_div);
    assign bit_pos  = lsb_first ? idx : (fsz - idx);

    // next-state logic
    always_comb begin
        state_n   = state;
        tx_pop    = 1'b0;
        frame_end = 1'b0;
        unique case (state)
            ST_IDLE:  if (start_ok) begin
                          state_n = ST_SETUP;
                          tx_pop  = 1'b1;
                      end
            ST_SETUP: if (half_end) state_n = ST_HALF1;
            ST_HALF1: if (half_end) state_n = ST_HALF2;
            ST_HALF2: if (half_end) state_n = (idx == fsz) ? ST_HOLD : ST_HALF1;
            ST_HOLD:  if (half_end) begin
                          state_n   = ST_IDLE;
                          frame_end = 1'b1;
                      end
            default:  state_n = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tick    <= '0;
            idx     <= '0;
            cmd_q   <= '0;
            data_q  <= '0;
            rx_sh   <= '0;
            cs_hold <= '0;
        end else begin
            state <= state_n;
            if (state_n != state || state == ST_IDLE) tick <= '0;
            else                                      tick <= tick + 1'b1;
            if (tx_pop) begin
                cmd_q  <= tx_word[31:16];
                data_q <= tx_word[DATA_W-1:0];
                idx    <= '0;
                rx_sh  <= '0;
            end
            if (state == ST_HALF1 && half_end) rx_sh[bit_pos] <= miso;
            if (state == ST_HALF2 && half_end && idx != fsz) idx <= idx + 1'b1;
            if (frame_end) cs_hold <= cmd_q[CMD_CONT] ? cmd_q[CS_W-1:0] : '0;
        end
    end

    // outputs
    always_comb begin
        sck    = cpol;
        mosi   = 1'b0;
        cs_act = cmd_q[CS_W-1:0];
        unique case (state)
            ST_IDLE:  cs_act = cs_hold;
            ST_SETUP: mosi = data_q[bit_pos];
            ST_HALF1: begin
                          sck  = cpol ^ cpha;
                          mosi = data_q[bit_pos];
                      end
            ST_HALF2: begin
                          sck  = ~(cpol ^ cpha);
                          mosi = data_q[bit_pos];
                      end
            ST_HOLD:  sck = cpol;
            default:  cs_act = '0;
        endcase
    end

    assign busy      = (state != ST_IDLE);
    assign frame_eoq = frame_end & cmd_q[CMD_EOQ];
    assign cnt_clear = tx_pop & tx_word[16 + CMD_CLR];
    assign rx_data   = rx_sh;
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    parameter int DIV_W    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            irq,
    output logic            sck,
    output logic            mosi,
    input  logic            miso,
    output logic [CS_W-1:0] sel_o
);
    localparam logic [FSZ_W-1:0] FSZ_MIN = FSZ_W'(3);

    logic                master_en;
    logic [CS_W-1:0]     idle_lvl;
    logic [FSZ_W-1:0]    fsz_fld, fsz_eff;
    logic                cpol, cpha, lsb_first;
    logic [DIV_W-1:0]    half_div;
    logic [15:0]         xfer_cnt;
    logic                st_done, st_eoq, st_ovf, st_udf;
    logic                ie_done, ie_eoq;

    logic wr_ctrl, wr_attr, wr_stat, wr_irqen, push_wr, pop_rd;
    logic tx_flush, rx_flush;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [31:0]         tx_head;
    logic [DATA_W-1:0]   rx_head, rx_din;
    logic tx_pop, rx_push, frame_done, frame_eoq, cnt_clear, busy;
    logic [CS_W-1:0]     cs_act;
    logic [31:0]         rd_mux;

    assign wr_ctrl  = reg_wr && reg_addr == RA_CTRL;
    assign wr_attr  = reg_wr && reg_addr == RA_ATTR;
    assign wr_stat  = reg_wr && reg_addr == RA_STAT;
    assign wr_irqen = reg_wr && reg_addr == RA_IRQEN;
    assign push_wr  = reg_wr && reg_addr == RA_PUSH;
    assign pop_rd   = reg_rd && reg_addr == RA_POP;
    assign tx_flush = wr_ctrl && reg_wdata[CB_FLTX];
    assign rx_flush = wr_ctrl && reg_wdata[CB_FLRX];
    assign fsz_eff  = (fsz_fld < FSZ_MIN) ? FSZ_MIN : fsz_fld;

    spim_fifo #(.W(32), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(push_wr), .din(reg_wdata), .pop(tx_pop),
        .dout(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_push), .din(rx_din), .pop(pop_rd),
        .dout(rx_head), .full(rx_full), .empty(rx_empty)
    );

    spim_core #(.DIV_W(DIV_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .start_ok(master_en && !tx_empty && !rx_full),
        .tx_word(tx_head), .fsz(fsz_eff), .cpol(cpol), .cpha(cpha),
        .lsb_first(lsb_first), .half_div(half_div), .miso(miso),
        .tx_pop(tx_pop), .frame_end(frame_done), .frame_eoq(frame_eoq),
        .cnt_clear(cnt_clear), .rx_data(rx_din), .cs_act(cs_act),
        .busy(busy), .sck(sck), .mosi(mosi)
    );

    assign rx_push = frame_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_en <= 1'b0;
            idle_lvl  <= '1;
            fsz_fld   <= FSZ_W'(7);
            cpol      <= 1'b0;
            cpha      <= 1'b0;
            lsb_first <= 1'b0;
            half_div  <= '0;
            xfer_cnt  <= '0;
            st_done   <= 1'b0;
            st_eoq    <= 1'b0;
            st_ovf    <= 1'b0;
            st_udf    <= 1'b0;
            ie_done   <= 1'b0;
            ie_eoq    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                master_en <= reg_wdata[CB_EN];
                idle_lvl  <= reg_wdata[CB_LVL +: CS_W];
            end
            if (wr_attr) begin
                fsz_fld   <= reg_wdata[FSZ_W-1:0];
                cpol      <= reg_wdata[4];
                cpha      <= reg_wdata[5];
                lsb_first <= reg_wdata[6];
                half_div  <= reg_wdata[8 +: DIV_W];
            end
            if (wr_irqen) begin
                ie_done <= reg_wdata[SB_DONE];
                ie_eoq  <= reg_wdata[SB_EOQ];
            end
            if (cnt_clear)       xfer_cnt <= '0;
            else if (frame_done) xfer_cnt <= xfer_cnt + 16'd1;
            st_done <= (st_done & ~(wr_stat & reg_wdata[SB_DONE])) | frame_done;
            st_eoq  <= (st_eoq  & ~(wr_stat & reg_wdata[SB_EOQ]))  | frame_eoq;
            st_ovf  <= (st_ovf  & ~(wr_stat & reg_wdata[SB_OVF]))  | (push_wr & tx_full);
            st_udf  <= (st_udf  & ~(wr_stat & reg_wdata[SB_UDF]))  | (pop_rd & rx_empty);
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (reg_addr)
            RA_CTRL: begin
                rd_mux[CB_EN]            = master_en;
                rd_mux[CB_LVL +: CS_W]   = idle_lvl;
            end
            RA_ATTR: begin
                rd_mux[FSZ_W-1:0]        = fsz_fld;
                rd_mux[4]                = cpol;
                rd_mux[5]                = cpha;
                rd_mux[6]                = lsb_first;
                rd_mux[8 +: DIV_W]       = half_div;
            end
            RA_COUNT: rd_mux[31:16]      = xfer_cnt;
            RA_STAT: begin
                rd_mux[SB_DONE]          = st_done;
                rd_mux[SB_EOQ]           = st_eoq;
                rd_mux[SB_OVF]           = st_ovf;
                rd_mux[SB_UDF]           = st_udf;
            end
            RA_IRQEN: begin
                rd_mux[SB_DONE]          = ie_done;
                rd_mux[SB_EOQ]           = ie_eoq;
            end
            RA_POP:  rd_mux[DATA_W-1:0]  = rx_empty ? '0 : rx_head;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    assign irq   = (st_done & ie_done) | (st_eoq & ie_eoq);
    assign sel_o = idle_lvl ^ cs_act;
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_push,
    input logic              rx_full,
    input logic [DATA_W-1:0] rx_din,
    input logic [3:0]        fsz,
    input logic              push_wr,
    input logic              tx_full,
    input logic              pop_rd,
    input logic              rx_empty,
    input logic              st_ovf,
    input logic              st_udf,
    input logic              st_done,
    input logic [31:0]       reg_rdata,
    input logic              frame_done,
    input logic [15:0]       xfer_cnt,
    input logic              busy,
    input logic              sck,
    input logic              cpol
);
    logic [DATA_W-1:0] fmask;
    assign fmask = DATA_W'((32'd2 << fsz) - 32'd1);

    // R14
    rx_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);

    // R11
    tx_overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_wr && tx_full) |=> st_ovf);

    // R12
    rx_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_rd && rx_empty) |=> (reg_rdata == 32'd0 && st_udf));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (xfer_cnt == $past(xfer_cnt) + 16'd1));

    // R9
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> st_done);

    // R5
    rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> ((rx_din & ~fmask) == '0));

    // R3
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cpol));
endmodule

bind spim_engine spim_chk #(.DATA_W(spim_pkg::DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_full(rx_full),
    .rx_din(rx_din), .fsz(fsz_eff), .push_wr(push_wr), .tx_full(tx_full),
    .pop_rd(pop_rd), .rx_empty(rx_empty), .st_ovf(st_ovf), .st_udf(st_udf),
    .st_done(st_done), .reg_rdata(reg_rdata), .frame_done(frame_done),
    .xfer_cnt(xfer_cnt), .busy(busy), .sck(sck), .cpol(cpol)
);

// File: tb/sim_spim_engine.sv
`timescale 1ns/1ps
module sim_spim_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, sck, mosi, miso;
    logic [5:0]  sel_o;

    always #2 clk = ~clk;
    assign miso = ~mosi;

    spim_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .sel_o(sel_o)
    );

    int checks = 0, fails = 0;

    // bench-side view of configuration
    logic       cpol_b = 1'b0, cpha_b = 1'b0;
    logic [5:0] lvl_b = 6'h3F;
    int         clr_req = 0, clr_seen = 0;

    // wire monitor
    logic [15:0] cap;
    int          nbits, gmin, gmax, last_edge, cyc, desel_cnt, idle_bad;
    logic [5:0]  seen_cs;
    logic        prev_sck, prev_act;

    initial begin
        cyc = 0; cap = '0; nbits = 0; gmin = 1000; gmax = 0; last_edge = -1;
        desel_cnt = 0; idle_bad = 0; seen_cs = '0; prev_sck = 1'b0; prev_act = 1'b0;
    end

    always @(negedge clk) begin
        logic [5:0] a;
        logic       lead;
        int         gap;
        cyc++;
        a = sel_o ^ lvl_b;
        if (clr_req != clr_seen) begin
            clr_seen = clr_req;
            cap = '0; nbits = 0; gmin = 1000; gmax = 0; last_edge = -1;
            desel_cnt = 0; idle_bad = 0; seen_cs = '0;
            prev_sck = sck; prev_act = (a != 0);
        end
        seen_cs |= a;
        if (prev_act && a == 0) desel_cnt++;
        if (a == 0 && sck !== cpol_b) idle_bad++;
        if (a != 0 && sck !== prev_sck) begin
            lead = (sck !== cpol_b);
            if (lead != cpha_b) begin
                cap = {cap[14:0], mosi};
                nbits++;
            end
            if (last_edge >= 0) begin
                gap = cyc - last_edge;
                if (gap < gmin) gmin = gap;
                if (gap > gmax) gmax = gap;
            end
            last_edge = cyc;
        end
        prev_sck = sck;
        prev_act = (a != 0);
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] nmask(input int n);
        return 16'((32'd1 << n) - 32'd1);
    endfunction

    function automatic logic [15:0] rev_n(input logic [15:0] d, input int n);
        logic [15:0] r = '0;
        for (int i = 0; i < n; i++) r[n-1-i] = d[i];
        return r;
    endfunction

    function automatic logic [31:0] pword(input logic [5:0] cs, input bit cont,
                                          input bit eoq, input bit clr, input logic [15:0] d);
        logic [15:0] c = '0;
        c[5:0] = cs; c[15] = cont; c[11] = eoq; c[10] = clr;
        return {c, d};
    endfunction

    task automatic set_attr(input int fld, input int mode, input bit lsb, input int div);
        logic [31:0] v = '0;
        v[3:0] = 4'(fld); v[4] = mode[1]; v[5] = mode[0]; v[6] = lsb; v[15:8] = 8'(div);
        wr(3'd1, v);
        cpol_b = mode[1];
        cpha_b = mode[0];
        clr_req++;
    endtask

    // one frame: wire, chip select, idle level and receive checks
    task automatic run_frame(input int fld, input int mode, input bit lsb, input logic [15:0] d, input int k);
        int n;
        logic [15:0] wexp;
        logic [31:0] r;
        n = (fld < 3) ? 4 : fld + 1;
        set_attr(fld, mode, lsb, 0);
        wr(3'd5, pword(6'(1 << k), 1'b0, 1'b0, 1'b0, d));
        idle(45);
        wexp = lsb ? rev_n(d, n) : (d & nmask(n));
        chk(nbits == n, "R2 bit count", 32'(nbits), 32'(n));
        if (lsb) chk((cap & nmask(n)) == wexp, "R4 lsb-first wire", 32'(cap & nmask(n)), 32'(wexp));
        else     chk((cap & nmask(n)) == wexp, "R2 msb-first wire", 32'(cap & nmask(n)), 32'(wexp));
        chk(idle_bad == 0, "R3 idle sck level", 32'(idle_bad), 32'd0);
        chk(seen_cs == 6'(1 << k), "R6 selected line", 32'(seen_cs), 32'(1 << k));
        rd(3'd6, r);
        chk(r == 32'(~d & nmask(n)), "R5 pop data", r, 32'(~d & nmask(n)));
    endtask

    logic [31:0] r;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(sel_o == 6'h3F, "R1 sel_o", 32'(sel_o), 32'h3F);
        chk(sck == 1'b0 && irq == 1'b0, "R1 sck/irq", {30'd0, sck, irq}, 32'd0);
        rd(3'd0, r); chk(r == 32'h3F00, "R1 control", r, 32'h3F00);
        rd(3'd1, r); chk(r == 32'h7, "R1 attributes", r, 32'h7);
        rd(3'd3, r); chk(r == 32'h0, "R1 status", r, 32'h0);
        rd(3'd2, r); chk(r == 32'h0, "R1 count", r, 32'h0);

        wr(3'd0, 32'h3F01);

        // sweep: length field x clock mode x bit order (R2 R3 R4 R5 R6)
        for (int fld = 1; fld < 16; fld++)
            for (int mode = 0; mode < 4; mode++)
                for (int lsb = 0; lsb < 2; lsb++)
                    run_frame(fld, mode, lsb[0],
                              16'(16'hB5A3 ^ (fld * 16'h1357) ^ (mode * 16'h0F0F) ^ (lsb * 16'h8001)),
                              (fld + mode + lsb) % 6);

        // R3 divider: half period of three cycles
        set_attr(7, 1, 1'b0, 2);
        wr(3'd5, pword(6'h01, 1'b0, 1'b0, 1'b0, 16'h00C6));
        idle(80);
        chk(gmin == 3 && gmax == 3, "R3 half period", {gmin[15:0], gmax[15:0]}, {16'd3, 16'd3});
        chk(nbits == 8 && (cap & 16'hFF) == 16'hC6, "R3 slow wire", 32'(cap), 32'hC6);
        rd(3'd6, r);

        // R6 programmed idle level
        set_attr(7, 0, 1'b0, 0);
        wr(3'd0, 32'h2A01);
        lvl_b = 6'h2A;
        clr_req++;
        chk(sel_o == 6'h2A, "R6 idle level", 32'(sel_o), 32'h2A);
        wr(3'd5, pword(6'h01, 1'b0, 1'b0, 1'b0, 16'h005A));
        idle(40);
        chk(seen_cs == 6'h01, "R6 inverted assert", 32'(seen_cs), 32'h01);
        chk(sel_o == 6'h2A, "R6 release level", 32'(sel_o), 32'h2A);
        rd(3'd6, r);
        wr(3'd0, 32'h3F01);
        lvl_b = 6'h3F;
        clr_req++;
        idle(2);

        // R7 continue bit
        clr_req++;
        wr(3'd5, pword(6'h02, 1'b1, 1'b0, 1'b0, 16'h0011));
        wr(3'd5, pword(6'h02, 1'b0, 1'b0, 1'b0, 16'h0022));
        idle(70);
        chk(desel_cnt == 1, "R7 held between frames", 32'(desel_cnt), 32'd1);
        clr_req++;
        wr(3'd5, pword(6'h02, 1'b0, 1'b0, 1'b0, 16'h0033));
        wr(3'd5, pword(6'h02, 1'b0, 1'b0, 1'b0, 16'h0044));
        idle(70);
        chk(desel_cnt == 2, "R7 released between frames", 32'(desel_cnt), 32'd2);
        for (int i = 0; i < 4; i++) rd(3'd6, r);

        // R8 transfer count
        wr(3'd5, pword(6'h01, 1'b0, 1'b0, 1'b1, 16'h0001));
        wr(3'd5, pword(6'h01, 1'b0, 1'b0, 1'b0, 16'h0002));
        wr(3'd5, pword(6'h01, 1'b0, 1'b0, 1'b0, 16'h0003));
        idle(100);
        rd(3'd2, r); chk(r == 32'h0003_0000, "R8 accumulate", r, 32'h0003_0000);
        wr(3'd5, pword(6'h01, 1'b0, 1'b0, 1'b1, 16'h0004));
        idle(40);
        rd(3'd2, r); chk(r == 32'h0001_0000, "R8 clear frame", r, 32'h0001_0000);
        for (int i = 0; i < 4; i++) rd(3'd6, r);

        // R9 status flags
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd5, pword(6'h01, 1'b0, 1'b0, 1'b0, 16'h0055));
        idle(40);
        rd(3'd3, r); chk(r == 32'h8000_0000, "R9 done flag", r, 32'h8000_0000);
        wr(3'd3, 32'h8000_0000);
        rd(3'd3, r); chk(r == 32'h0, "R9 done cleared", r, 32'h0);
        wr(3'd5, pword(6'h01, 1'b0, 1'b1, 1'b0, 16'h0066));
        idle(40);
        rd(3'd3, r); chk(r == 32'h9000_0000, "R9 eoq flag", r, 32'h9000_0000);
        wr(3'd3, 32'h9000_0000);
        rd(3'd3, r); chk(r == 32'h0, "R9 both cleared", r, 32'h0);
        rd(3'd6, r); rd(3'd6, r);

        // R10 interrupt enable
        wr(3'd4, 32'h1000_0000);
        wr(3'd5, pword(6'h01, 1'b0, 1'b0, 1'b0, 16'h0077));
        idle(40);
        chk(irq == 1'b0, "R10 masked done", 32'(irq), 32'd0);
        wr(3'd5, pword(6'h01, 1'b0, 1'b1, 1'b0, 16'h0088));
        idle(40);
        chk(irq == 1'b1, "R10 eoq irq", 32'(irq), 32'd1);
        wr(3'd3, 32'h1000_0000);
        idle(1);
        chk(irq == 1'b0, "R10 irq cleared", 32'(irq), 32'd0);
        wr(3'd4, 32'h8000_0000);
        idle(1);
        chk(irq == 1'b1, "R10 done irq", 32'(irq), 32'd1);
        wr(3'd4, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd6, r); rd(3'd6, r);

        // R11 overflow, R12 underflow
        wr(3'd0, 32'h3F00);
        for (int i = 0; i < 5; i++)
            wr(3'd5, pword(6'h01, 1'b0, 1'b0, (i == 0), 16'(16'h0010 + i)));
        rd(3'd3, r); chk(r == 32'h2, "R11 overflow flag", r, 32'h2);
        wr(3'd0, 32'h3F01);
        idle(160);
        rd(3'd2, r); chk(r == 32'h0004_0000, "R11 fifth push dropped", r, 32'h0004_0000);
        for (int i = 0; i < 4; i++) begin
            rd(3'd6, r);
            chk(r == 32'(~(16'h0010 + i) & 16'hFF), "R11 kept order", r, 32'(~(16'h0010 + i) & 16'hFF));
        end
        rd(3'd6, r); chk(r == 32'h0, "R12 empty pop value", r, 32'h0);
        rd(3'd3, r); chk(r[0] == 1'b1, "R12 underflow flag", r, 32'h1);
        wr(3'd3, 32'hFFFF_FFFF);

        // R14 receive-full stall
        for (int i = 0; i < 4; i++)
            wr(3'd5, pword(6'h01, 1'b0, 1'b0, (i == 0), 16'(16'h0020 + i)));
        idle(160);
        wr(3'd5, pword(6'h01, 1'b0, 1'b0, 1'b0, 16'h0024));
        idle(100);
        rd(3'd2, r); chk(r == 32'h0004_0000, "R14 stalled while full", r, 32'h0004_0000);
        rd(3'd6, r); chk(r == 32'h00DF, "R14 first frame", r, 32'h00DF);
        idle(40);
        rd(3'd2, r); chk(r == 32'h0005_0000, "R14 resumed after pop", r, 32'h0005_0000);
        for (int i = 0; i < 4; i++) rd(3'd6, r);
        chk(r == 32'h00DB, "R14 waiting frame kept", r, 32'h00DB);

        // R14 disabled master holds queued words; R13 transmit flush
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd0, 32'h3F00);
        for (int i = 0; i < 3; i++)
            wr(3'd5, pword(6'h01, 1'b0, 1'b0, 1'b1, 16'h0030));
        idle(60);
        rd(3'd2, r); chk(r == 32'h0005_0000, "R14 disabled no start", r, 32'h0005_0000);
        wr(3'd0, 32'h3F10);
        wr(3'd0, 32'h3F01);
        idle(100);
        rd(3'd2, r); chk(r == 32'h0005_0000, "R13 tx flush", r, 32'h0005_0000);
        rd(3'd3, r); chk(r == 32'h0, "R13 no frame after flush", r, 32'h0);

        // R13 receive flush
        wr(3'd5, pword(6'h01, 1'b0, 1'b0, 1'b0, 16'h0040));
        wr(3'd5, pword(6'h01, 1'b0, 1'b0, 1'b0, 16'h0041));
        idle(80);
        wr(3'd0, 32'h3F21);
        rd(3'd6, r); chk(r == 32'h0, "R13 rx flush value", r, 32'h0);
        rd(3'd3, r); chk(r[0] == 1'b1, "R13 rx flush empty", r, 32'h8000_0001);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule